// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Two-Bit Address Counter

This block is a single-port synchronous static RAM meant as the data array of a cache. Every input except the output enable is sampled on the rising clock edge. A cycle is opened by either of two transfer-start inputs: one is driven from the processor side and the other from the cache controller. Each one loads a fresh external address. The two low address bits then come from an internal counter that steps only when the burst-advance input is high. The counter wraps modulo 4 in linear order from the loaded value, so a burst is four beats long, and the upper address bits stay fixed for the whole burst.

Writes are split into two 9-bit byte lanes with a separate enable for each lane. A write lands in the array on the same edge that samples it, with no externally timed write pulse. The data bus is presented to the pad ring as a three-state bus in split form: a read-data vector plus a drive enable. The drive enable follows the output-enable input combinationally, with no clock involved. The word count is set by the address width parameter. A 16-bit address gives the full 65,536 x 18 array, and the default is kept small for elaboration.

Top module: `sbr_burst_sram`

## Requirements
- R1: After a synchronous active-low reset, no cycle is open and `data_oe` stays 0 even with `out_en` high, until a valid start is sampled.
- R2: A controller start (`start_ctl`=1) sampled with `chip_en`=1 loads `addr_in` as the current address. After that edge, `data_out` shows the word stored at that address.
- R3: A processor start (`start_cpu`=1) also loads `addr_in`, but that edge is a read: `wr_lo` and `wr_hi` are ignored on it and the array keeps its contents.
- R4: On an edge with `burst_adv`=1, an open cycle and no start, the low 2 address bits advance by one modulo 4 (3 wraps to 0). The upper address bits keep the value that was loaded.
- R5: On an edge with no start and `burst_adv`=0, the current address is held.
- R6: `wr_lo` writes only data bits 8:0 and `wr_hi` writes only bits 17:9. The other lane of the word is left unchanged.
- R7: A write is taken on the edge that samples it. It goes to the newly loaded address on a controller-start edge, or to the advanced address on a burst edge. Reading that address on the next edge returns the written lanes.
- R8: `data_oe` = `out_en` AND (cycle open), combinationally and without a clock. When `data_oe` is 0, `data_out` is all zeros.
- R9: A start sampled with `chip_en`=0 closes the cycle. No data is driven, and writes and advances are ignored until the next start with `chip_en`=1.
- R10: If both start inputs are high on one edge, the processor-start rule applies: the address loads and the write enables are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External word address, loaded on a start |
| data_in | input | 18 | Write data (inbound half of the three-state bus) |
| start_cpu | input | 1 | Processor-side transfer start (read only) |
| start_ctl | input | 1 | Controller-side transfer start |
| chip_en | input | 1 | Chip enable, sampled together with a start |
| burst_adv | input | 1 | Advance the burst counter |
| wr_lo | input | 1 | Write enable for bits 8:0 |
| wr_hi | input | 1 | Write enable for bits 17:9 |
| out_en | input | 1 | Asynchronous output enable |
| data_out | output | 18 | Read data (outbound half of the bus), zero when not driven |
| data_oe | output | 1 | Bus drive enable for the pad ring |

## Verification
Suppose the burst counter steps wrongly, fails to wrap, or disturbs the upper address bits. The wrong word then appears on `data_out` after the very next edge, so every beat of a burst is compared against a bench model. A bad cycle-open flag shows up as `data_oe` being high or low on the cycle after a start with chip enable low. A leaked write (on a processor start, a closed cycle, or the wrong lane) stays hidden until that address is read again. For that reason each such stimulus is followed by a read-back of the words it could have touched.

// File: rtl/sbr_pkg.sv
// Package: shared widths for the burst SRAM.
// Assumes two byte lanes of nine bits; the lane count drives the generate in the top.
package sbr_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;
    localparam int BURST_W = 2;   // counter width: four-beat bursts
endpackage

// File: rtl/sbr_cycle_ctrl.sv
// Cycle control: decodes the two start inputs and chip enable into a load strobe,
// the cycle-open flag and per-lane write strobes for the current edge.
// Assumes inputs are stable around the rising edge; the processor start wins when both fire.
module sbr_cycle_ctrl #(
    parameter int LANES = sbr_pkg::LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cpu,
    input  logic             start_ctl,
    input  logic             chip_en,
    input  logic [LANES-1:0] lane_req,
    output logic             load,
    output logic             open_now,
    output logic             open_next,
    output logic [LANES-1:0] lane_we
);
    logic open_q;

    // Decode: any start loads; the new open state comes from chip enable.
    always_comb begin
        load      = start_cpu | start_ctl;
        open_next = load ? chip_en : open_q;
    end

    // Write strobes: only an open cycle not begun by the processor may write.
    always_comb begin
        lane_we = (open_next && !start_cpu) ? lane_req : '0;
    end

    // State: cycle-open flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_next;
    end

    assign open_now = open_q;

    // R3 / R10: a processor start never writes.
    p_cpu_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_cpu |-> (lane_we == '0));

    // R9: a start with chip enable low leaves the cycle closed afterwards.
    p_ce_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !chip_en) |=> !open_now);

    // R9: a closed cycle stays closed until a start.
    p_stay_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_now && !load) |=> !open_now);
endmodule

// File: rtl/sbr_burst_addr.sv
// Burst address generator: loads the external address on a start and then steps
// the low counter bits modulo the burst length when told to advance.
// Assumes ADDR_W >= BURST_W; upper bits are frozen for the burst.
module sbr_burst_addr #(
    parameter int ADDR_W  = 10,
    parameter int BURST_W = sbr_pkg::BURST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic              open_now,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_next,
    output logic [ADDR_W-1:0] addr_cur
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    hi_q;
    logic [BURST_W-1:0] cnt_q;
    logic [HI_W-1:0]    hi_d;
    logic [BURST_W-1:0] cnt_d;

    // Next address: load wins, else wrap-around step, else hold.
    always_comb begin
        hi_d  = hi_q;
        cnt_d = cnt_q;
        if (load) begin
            hi_d  = addr_in[ADDR_W-1:BURST_W];
            cnt_d = addr_in[BURST_W-1:0];
        end else if (advance && open_now) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // Registers for the upper part and the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            cnt_q <= '0;
        end else begin
            hi_q  <= hi_d;
            cnt_q <= cnt_d;
        end
    end

    assign addr_next = {hi_d, cnt_d};
    assign addr_cur  = {hi_q, cnt_q};

    // R4: an advance steps the counter by one and leaves the upper bits alone.
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (open_now && !load && advance) |=>
            (addr_cur[BURST_W-1:0] == BURST_W'($past(addr_cur[BURST_W-1:0]) + 1'b1)) &&
            (addr_cur[ADDR_W-1:BURST_W] == $past(addr_cur[ADDR_W-1:BURST_W])));

    // R5: without start or advance the address does not move.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> $stable(addr_cur));

    // R2: a start places the external address in the current address.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_cur == $past(addr_in)));
endmodule

// File: rtl/sbr_lane_array.sv
// One byte lane of the storage array: write on the clock edge, combinational read.
// Assumes storage is not reset, like a real SRAM; DEPTH is 2**ADDR_W words.
module sbr_lane_array #(
    parameter int ADDR_W = 10,
    parameter int WIDTH  = sbr_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    // Self-timed write: data reaches the cell on the sampling edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sbr_burst_sram.sv
// Top: synchronous burst SRAM with two start inputs, a wrapping burst counter,
// two byte lanes and an asynchronous output enable onto a split three-state bus.
// Assumes the pad ring merges data_out/data_oe with data_in; ADDR_W=16 gives 64K words.
module sbr_burst_sram #(
    parameter int ADDR_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr_in,
    input  logic [sbr_pkg::DATA_W-1:0] data_in,
    input  logic                      start_cpu,
    input  logic                      start_ctl,
    input  logic                      chip_en,
    input  logic                      burst_adv,
    input  logic                      wr_lo,
    input  logic                      wr_hi,
    input  logic                      out_en,
    output logic [sbr_pkg::DATA_W-1:0] data_out,
    output logic                      data_oe
);
    import sbr_pkg::*;

    logic              load;
    logic              open_now;
    logic              open_next;
    logic [LANES-1:0]  lane_req;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] addr_next;
    logic [ADDR_W-1:0] addr_cur;
    logic [DATA_W-1:0] rd_word;

    assign lane_req = {wr_hi, wr_lo};

    sbr_cycle_ctrl #(.LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cpu (start_cpu),
        .start_ctl (start_ctl),
        .chip_en   (chip_en),
        .lane_req  (lane_req),
        .load      (load),
        .open_now  (open_now),
        .open_next (open_next),
        .lane_we   (lane_we)
    );

    sbr_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (burst_adv),
        .open_now  (open_now),
        .addr_in   (addr_in),
        .addr_next (addr_next),
        .addr_cur  (addr_cur)
    );

    // One storage instance per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sbr_lane_array #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_lane (
            .clk   (clk),
            .we    (lane_we[g]),
            .waddr (addr_next),
            .wdata (data_in[g*LANE_W +: LANE_W]),
            .raddr (addr_cur),
            .rdata (rd_word[g*LANE_W +: LANE_W])
        );
    end

    // Output stage: asynchronous enable gates the read word onto the bus.
    always_comb begin
        data_oe  = out_en && open_now;
        data_out = data_oe ? rd_word : '0;
    end

    // R8: the bus is driven only with output enable high in an open cycle.
    p_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (out_en && open_now));

    // R8: an undriven bus carries zeros.
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0));

    // R9: nothing is written into a closed cycle.
    p_no_write_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !open_next |-> (lane_we == '0));

    // R1: the cycle is closed right after reset.
    p_reset_closed_r1: assert property (@(posedge clk)
        !rst_n |=> !open_now);
endmodule

// File: tb/sbr_burst_sram_tb.sv
// Scoreboard bench: the driver steps a model of the requirements and queues the
// expected bus state; the monitor compares after each edge.
module sbr_burst_sram_tb_top;
    localparam int PERIOD = 10;
    localparam int AW     = 10;

    typedef struct {
        bit          oe;
        bit          known;
        logic [17:0] data;
        string       req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [17:0]   data_in = '0;
    logic          start_cpu = 1'b0, start_ctl = 1'b0, chip_en = 1'b0, burst_adv = 1'b0;
    logic          wr_lo = 1'b0, wr_hi = 1'b0, out_en = 1'b0;
    logic [17:0]   data_out;
    logic          data_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    exp_t        sb_q[$];
    logic [17:0] mdl_mem [int];
    bit          mdl_open = 1'b0;
    int          mdl_addr = 0;

    localparam logic [17:0] D0 = 18'h2AB55, D1 = 18'h1C3E7, D2 = 18'h0F00F, D3 = 18'h3A5C1;

    sbr_burst_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .data_in(data_in),
        .start_cpu(start_cpu), .start_ctl(start_ctl), .chip_en(chip_en),
        .burst_adv(burst_adv), .wr_lo(wr_lo), .wr_hi(wr_hi), .out_en(out_en),
        .data_out(data_out), .data_oe(data_oe)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of stimulus, advance the model, queue the expectation.
    task automatic step(input bit sc, input bit sp, input bit adv, input bit ce,
                        input bit wl, input bit wh, input bit oe,
                        input int a, input logic [17:0] d, input string req);
        exp_t e;
        logic [17:0] w;
        @(negedge clk);
        start_ctl = sc; start_cpu = sp; burst_adv = adv; chip_en = ce;
        wr_lo = wl; wr_hi = wh; out_en = oe; addr_in = AW'(a); data_in = d;
        if (sp || sc) begin
            mdl_open = ce;
            mdl_addr = a;
        end else if (adv && mdl_open) begin
            mdl_addr = (mdl_addr & ~3) | ((mdl_addr + 1) & 3);
        end
        if (mdl_open && !sp && (wl || wh)) begin
            w = mdl_mem.exists(mdl_addr) ? mdl_mem[mdl_addr] : 18'h0;
            if (wl) w[8:0]  = d[8:0];
            if (wh) w[17:9] = d[17:9];
            mdl_mem[mdl_addr] = w;
        end
        e.oe    = oe && mdl_open;
        e.known = mdl_open && mdl_mem.exists(mdl_addr);
        e.data  = e.known ? mdl_mem[mdl_addr] : 18'h0;
        e.req   = req;
        sb_q.push_back(e);
    endtask

    task automatic idle(input bit oe, input string req);
        step(0, 0, 0, 0, 0, 0, oe, 0, 18'h0, req);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(posedge clk);
        #(PERIOD/2);
    endtask

    // Monitor: compare outputs a quarter period after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (sb_q.size() != 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(data_oe == e.oe, {e.req, " drive"}, {17'h0, data_oe}, {17'h0, e.oe});
                if (e.oe && e.known)
                    check(data_out == e.data, {e.req, " data"}, data_out, e.data);
                if (!e.oe)
                    check(data_out == 18'h0, {e.req, " quiet"}, data_out, 18'h0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        out_en = 1'b1;
        @(posedge clk);
        #(PERIOD/4);
        check(data_oe == 1'b0, "R1 reset closed", {17'h0, data_oe}, 18'h0);
        check(data_out == 18'h0, "R1 reset quiet", data_out, 18'h0);
        idle(1, "R1");

        // R7 / R4: write a four-beat burst through the controller start, then wrap.
        step(1, 0, 0, 1, 1, 1, 0, 'h104, D0, "R7 start write");
        step(0, 0, 1, 0, 1, 1, 0, 0, D1, "R7 beat1");
        step(0, 0, 1, 0, 1, 1, 0, 0, D2, "R7 beat2");
        step(0, 0, 1, 0, 1, 1, 0, 0, D3, "R7 beat3");
        step(0, 0, 1, 0, 0, 0, 1, 0, 18'h0, "R4 wrap to base");
        idle(1, "R5 hold");
        idle(1, "R5 hold again");

        // R2 / R4: controller read from the middle of a block, wrapping round.
        step(1, 0, 0, 1, 0, 0, 1, 'h106, 18'h0, "R2 load read");
        step(0, 0, 1, 0, 0, 0, 1, 0, 18'h0, "R4 step 3");
        step(0, 0, 1, 0, 0, 0, 1, 0, 18'h0, "R4 wrap 0");
        step(0, 0, 1, 0, 0, 0, 1, 0, 18'h0, "R4 step 1");

        // R3: processor start ignores write enables.
        step(0, 1, 0, 1, 1, 1, 1, 'h105, 18'h3FFFF, "R3 cpu start no write");
        // R6: single-lane writes on later beats.
        step(0, 0, 1, 0, 1, 0, 1, 0, 18'h00000, "R6 low lane write");
        idle(1, "R6 low lane readback");
        step(0, 0, 1, 0, 0, 1, 1, 0, 18'h3FFFF, "R6 high lane write");
        idle(1, "R6 high lane readback");

        // R9: chip enable low at start blocks drive, writes and advances.
        step(1, 0, 0, 0, 1, 1, 1, 'h104, 18'h12345, "R9 closed start");
        step(0, 0, 1, 0, 1, 1, 1, 0, 18'h23456, "R9 closed advance");
        step(1, 0, 0, 1, 0, 0, 1, 'h104, 18'h0, "R9 reopen read base");
        step(0, 0, 1, 0, 0, 0, 1, 0, 18'h0, "R9 reopen read next");

        // R10: both starts together behave as a read.
        step(1, 1, 0, 1, 1, 1, 1, 'h105, 18'h00000, "R10 both starts");
        idle(1, "R10 readback");
        drain();

        // R8: output enable acts without a clock edge.
        out_en = 1'b0;
        #1;
        check(data_oe == 1'b0, "R8 async off", {17'h0, data_oe}, 18'h0);
        check(data_out == 18'h0, "R8 async quiet", data_out, 18'h0);
        out_en = 1'b1;
        #1;
        check(data_oe == 1'b1, "R8 async on", {17'h0, data_oe}, 18'h1);
        check(data_out == D1, "R8 async data", data_out, D1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule